// File: doc/BRIEF.md
# Parallel SCSI Bus Protocol Controller

This block connects a small microprocessor port to an 8-bit parallel SCSI bus and lets software run either side of a bus exchange, as initiator or as target. The host reads and writes five byte-wide registers through a 3-bit address with active-low select and strobes. Every bus control line is driven straight from a register bit, so the firmware steps through the bus phases one edge at a time. The hardware adds odd parity on outgoing data, a parity check on incoming data, sticky interrupt causes with their own enables, a DMA request line, and a short arbitration sequence that bids with the device's own ID.

The bus side follows an open-drain model. Each line has an asserted-high drive output, meaning the line is pulled low, and an active-low sensed input from the cable. The controller treats a line as asserted when it drives that line itself or when the cable input is low. Host accesses are sampled on the block clock. Read side effects, the parity check and the clearing of interrupt flags, happen once, on the first clock of a read strobe.

Top module: `scsi_bus_ctrl`

## Requirements
- R1: After reset every drive output, `irq` and `dma_req` are 0, and addresses 1, 2 and 3 read as 0x00.
- R2: Address 2 reads back the mode byte as written. Address 1 reads back written bits 7 and 4..0, with bit 6 showing arbitration in progress and bit 5 showing arbitration lost, so written bits 6 and 5 are dropped. Address 3 reads its low nibble as written, bits 6..4 as 0, and bit 7 as the sticky end-of-process flag.
- R3: Address 1 bits drive control lines as follows: bit 7 drives RST, bit 4 ACK, bit 3 BSY, bit 2 SEL and bit 1 ATN. The `bus_ctl_drive`/`bus_ctl_in_n` index map is RST=8, BSY=7, REQ=6, MSG=5, C/D=4, I/O=3, SEL=2, ACK=1, ATN=0.
- R4: While address 1 bit 0 is set, the byte last written to address 0 appears on `bus_db_drive` and `bus_dbp_drive` carries the bit that makes the nine bits odd. While bit 0 is clear, both are 0.
- R5: Address 3 bits 3, 2, 1 and 0 drive REQ, MSG, C/D and I/O, but only while mode bit 6 (target) is set.
- R6: Reading address 0 returns the sensed data byte, where 1 means asserted, taken as the local drive OR the inverted cable input. Reading address 4 returns sensed RST, BSY, REQ, MSG, C/D, I/O, SEL and parity from bit 7 down to bit 0.
- R7: With mode bit 5 set, the first clock of a read of address 0 sets a parity error flag when the sensed data and parity carry an even count of ones. `irq` shows the flag only while mode bit 4 is set. With bit 5 clear, no flag is set.
- R8: An `eop_n` low sample sets the end-of-process flag. `irq` shows it only while mode bit 3 is set.
- R9: With mode bit 2 set, a busy-lost flag sets and raises `irq` exactly SETTLE clocks after the mode write when BSY stays unasserted, and never sets while BSY stays asserted.
- R10: Interrupt flags hold until reset or until the first clock of a read of address 4, which clears them all.
- R11: Setting mode bit 0 starts arbitration. The controller waits for BSY to stay free for SETTLE clocks, then drives BSY and the data bits of the ID byte written to address 4. After a further SETTLE clocks with no SEL and no higher data bit present, it keeps driving. Clearing bit 0 stops the drive.
- R12: If SEL is seen, or a data bit above the own ID is asserted, at the end of the bidding window, the controller stops driving, sets the lost flag and clears the in-progress flag.
- R13: `dma_req` is high only when mode bit 1 is set, REQ is sensed and `dma_ack_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_addr | input | 3 | Register address |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, 0 when not reading |
| hst_cs_n | input | 1 | Chip select, active low |
| hst_rd_n | input | 1 | Read strobe, active low |
| hst_wr_n | input | 1 | Write strobe, active low |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| dma_ack_n | input | 1 | DMA acknowledge, active low |
| eop_n | input | 1 | DMA end of process, active low |
| bus_ctl_in_n | input | 9 | Sensed control lines from the cable, active low |
| bus_ctl_drive | output | 9 | Control line pull-down enables |
| bus_db_in_n | input | 8 | Sensed data lines, active low |
| bus_db_drive | output | 8 | Data line pull-down enables |
| bus_dbp_in_n | input | 1 | Sensed parity line, active low |
| bus_dbp_drive | output | 1 | Parity line pull-down enable |

## Verification
A corrupted register shows up on the drive outputs on the very next clock, because every control, data and parity drive is a direct decode of stored bits. A wrong bit position therefore appears as the wrong line being pulled. A bad interrupt flag or a bad busy counter appears on `irq` right away, but a miscount only shows at the edge where the flag should rise, so the bench samples that edge exactly. An arbitration state error shows within two settle windows, as missing or extra BSY and ID drive, or as a wrong flag pair at address 1.

// File: rtl/scsi_ctrl_pkg.sv
package scsi_ctrl_pkg;

    localparam int DW    = 8;
    localparam int CTL_W = 9;

    // control line index map
    localparam int CTL_ATN = 0;
    localparam int CTL_ACK = 1;
    localparam int CTL_SEL = 2;
    localparam int CTL_IO  = 3;
    localparam int CTL_CD  = 4;
    localparam int CTL_MSG = 5;
    localparam int CTL_REQ = 6;
    localparam int CTL_BSY = 7;
    localparam int CTL_RST = 8;

    // register addresses
    localparam logic [2:0] ADR_DATA = 3'd0;
    localparam logic [2:0] ADR_ICMD = 3'd1;
    localparam logic [2:0] ADR_MODE = 3'd2;
    localparam logic [2:0] ADR_TCMD = 3'd3;
    localparam logic [2:0] ADR_STAT = 3'd4;

    // mode bits
    localparam int MD_ARB  = 0;
    localparam int MD_DMA  = 1;
    localparam int MD_MON  = 2;
    localparam int MD_EOPI = 3;
    localparam int MD_PARI = 4;
    localparam int MD_PARC = 5;
    localparam int MD_TGT  = 6;

    // writable bits of the initiator command byte
    localparam logic [DW-1:0] ICMD_MASK = 8'h9F;

    typedef enum logic [2:0] {
        ARB_IDLE,
        ARB_WAIT,
        ARB_BID,
        ARB_WON,
        ARB_LOST
    } arb_state_e;

endpackage

// File: rtl/scsi_parity.sv
module scsi_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] tx_data,
    output logic         tx_par,
    input  logic [W-1:0] rx_data,
    input  logic         rx_par,
    output logic         rx_bad
);
    // odd parity: data plus parity carry an odd number of ones
    assign tx_par = ~(^tx_data);
    assign rx_bad = ~(^{rx_data, rx_par});
endmodule

// File: rtl/scsi_arbiter.sv
module scsi_arbiter
    import scsi_ctrl_pkg::*;
#(
    parameter int SETTLE = 16,
    parameter int ID_W   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            bsy_seen,
    input  logic            sel_seen,
    input  logic [ID_W-1:0] db_seen,
    input  logic [ID_W-1:0] own_id,
    output logic            drive,
    output logic            busy,
    output logic            lost
);
    localparam int CNT_W = $clog2(SETTLE + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SETTLE - 1);

    typedef struct packed {
        arb_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             lost;
    } arb_t;

    arb_t q, d;
    logic [ID_W-1:0] others;

    assign others = db_seen & ~own_id;

    always_comb begin
        d = q;
        case (q.st)
            ARB_IDLE: begin
                if (start) begin
                    d.st   = ARB_WAIT;
                    d.cnt  = '0;
                    d.lost = 1'b0;
                end
            end
            ARB_WAIT: begin
                if (!start) begin
                    d.st = ARB_IDLE;
                end else if (bsy_seen) begin
                    d.cnt = '0;
                end else if (q.cnt == CNT_END) begin
                    d.st  = ARB_BID;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ARB_BID: begin
                if (!start) begin
                    d.st = ARB_IDLE;
                end else if (q.cnt == CNT_END) begin
                    if (sel_seen || (others > own_id)) begin
                        d.st   = ARB_LOST;
                        d.lost = 1'b1;
                    end else begin
                        d.st = ARB_WON;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ARB_WON, ARB_LOST: begin
                if (!start) d.st = ARB_IDLE;
            end
            default: d.st = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ARB_IDLE, cnt: '0, lost: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign drive = (q.st == ARB_BID) || (q.st == ARB_WON);
    assign busy  = (q.st == ARB_WAIT) || drive;
    assign lost  = q.lost;
endmodule

// File: rtl/scsi_irq_unit.sv
module scsi_irq_unit #(
    parameter int SETTLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_en,
    input  logic bsy_seen,
    input  logic eop_act,
    input  logic perr_evt,
    input  logic clear,
    input  logic par_irq_en,
    input  logic eop_irq_en,
    output logic irq,
    output logic eop_flag
);
    localparam int CNT_W = $clog2(SETTLE + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE);
    localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(SETTLE - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             perr;
        logic             eop;
        logic             bsy;
    } irq_t;

    irq_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d.perr = 1'b0;
            d.eop  = 1'b0;
            d.bsy  = 1'b0;
        end
        if (perr_evt) d.perr = 1'b1;
        if (eop_act)  d.eop  = 1'b1;
        if (!mon_en || bsy_seen) begin
            d.cnt = '0;
        end else if (q.cnt != CNT_MAX) begin
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CNT_HIT) d.bsy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign irq      = (q.perr && par_irq_en) || (q.eop && eop_irq_en) || q.bsy;
    assign eop_flag = q.eop;
endmodule

// File: rtl/scsi_bus_ctrl.sv
module scsi_bus_ctrl
    import scsi_ctrl_pkg::*;
#(
    parameter int SETTLE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       hst_addr,
    input  logic [DW-1:0]    hst_wdata,
    output logic [DW-1:0]    hst_rdata,
    input  logic             hst_cs_n,
    input  logic             hst_rd_n,
    input  logic             hst_wr_n,
    output logic             irq,
    output logic             dma_req,
    input  logic             dma_ack_n,
    input  logic             eop_n,
    input  logic [CTL_W-1:0] bus_ctl_in_n,
    output logic [CTL_W-1:0] bus_ctl_drive,
    input  logic [DW-1:0]    bus_db_in_n,
    output logic [DW-1:0]    bus_db_drive,
    input  logic             bus_dbp_in_n,
    output logic             bus_dbp_drive
);
    typedef struct packed {
        logic [DW-1:0] odr;
        logic [DW-1:0] icmd;
        logic [DW-1:0] mode;
        logic [3:0]    tcmd;
        logic [DW-1:0] own_id;
        logic          rd_prev;
    } regs_t;

    regs_t q, d;

    logic             acc, wr_act, rd_act, rd_start;
    logic             clr_evt, mode_wr, perr_evt;
    logic [CTL_W-1:0] ctl_seen;
    logic [DW-1:0]    db_seen;
    logic             dbp_seen;
    logic             tx_par, rx_bad;
    logic             arb_drive, arb_busy, arb_lost;
    logic             eop_flag;
    logic             tgt_mode, arb_start, data_en;

    assign acc      = !hst_cs_n;
    assign wr_act   = acc && !hst_wr_n;
    assign rd_act   = acc && !hst_rd_n;
    assign rd_start = rd_act && !q.rd_prev;
    assign clr_evt  = rd_start && (hst_addr == ADR_STAT);
    assign mode_wr  = wr_act && (hst_addr == ADR_MODE);

    assign tgt_mode  = q.mode[MD_TGT];
    assign arb_start = q.mode[MD_ARB];
    assign data_en   = q.icmd[0];

    // next-state logic
    always_comb begin
        d = q;
        d.rd_prev = rd_act;
        if (wr_act) begin
            case (hst_addr)
                ADR_DATA: d.odr    = hst_wdata;
                ADR_ICMD: d.icmd   = hst_wdata & ICMD_MASK;
                ADR_MODE: d.mode   = hst_wdata;
                ADR_TCMD: d.tcmd   = hst_wdata[3:0];
                ADR_STAT: d.own_id = hst_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // bus drive decode
    always_comb begin
        bus_ctl_drive          = '0;
        bus_ctl_drive[CTL_RST] = q.icmd[7];
        bus_ctl_drive[CTL_ACK] = q.icmd[4];
        bus_ctl_drive[CTL_BSY] = q.icmd[3] || arb_drive;
        bus_ctl_drive[CTL_SEL] = q.icmd[2];
        bus_ctl_drive[CTL_ATN] = q.icmd[1];
        bus_ctl_drive[CTL_REQ] = tgt_mode && q.tcmd[3];
        bus_ctl_drive[CTL_MSG] = tgt_mode && q.tcmd[2];
        bus_ctl_drive[CTL_CD]  = tgt_mode && q.tcmd[1];
        bus_ctl_drive[CTL_IO]  = tgt_mode && q.tcmd[0];
    end

    assign bus_db_drive  = (data_en ? q.odr : '0) | (arb_drive ? q.own_id : '0);
    assign bus_dbp_drive = data_en && tx_par;

    // sensed levels: own pull-down or someone else's
    assign ctl_seen = bus_ctl_drive | ~bus_ctl_in_n;
    assign db_seen  = bus_db_drive | ~bus_db_in_n;
    assign dbp_seen = bus_dbp_drive | ~bus_dbp_in_n;

    assign dma_req  = q.mode[MD_DMA] && ctl_seen[CTL_REQ] && dma_ack_n;
    assign perr_evt = rd_start && (hst_addr == ADR_DATA) && q.mode[MD_PARC] && rx_bad;

    // host read mux
    always_comb begin
        hst_rdata = '0;
        if (rd_act) begin
            case (hst_addr)
                ADR_DATA: hst_rdata = db_seen;
                ADR_ICMD: hst_rdata = {q.icmd[7], arb_busy, arb_lost, q.icmd[4:0]};
                ADR_MODE: hst_rdata = q.mode;
                ADR_TCMD: hst_rdata = {eop_flag, 3'b000, q.tcmd};
                ADR_STAT: hst_rdata = {ctl_seen[CTL_RST], ctl_seen[CTL_BSY],
                                       ctl_seen[CTL_REQ], ctl_seen[CTL_MSG],
                                       ctl_seen[CTL_CD],  ctl_seen[CTL_IO],
                                       ctl_seen[CTL_SEL], dbp_seen};
                default:  hst_rdata = '0;
            endcase
        end
    end

    scsi_parity #(.W(DW)) u_par (
        .tx_data (q.odr),
        .tx_par  (tx_par),
        .rx_data (db_seen),
        .rx_par  (dbp_seen),
        .rx_bad  (rx_bad)
    );

    scsi_arbiter #(.SETTLE(SETTLE), .ID_W(DW)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (arb_start),
        .bsy_seen (ctl_seen[CTL_BSY]),
        .sel_seen (ctl_seen[CTL_SEL]),
        .db_seen  (db_seen),
        .own_id   (q.own_id),
        .drive    (arb_drive),
        .busy     (arb_busy),
        .lost     (arb_lost)
    );

    scsi_irq_unit #(.SETTLE(SETTLE)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mon_en     (q.mode[MD_MON]),
        .bsy_seen   (ctl_seen[CTL_BSY]),
        .eop_act    (!eop_n),
        .perr_evt   (perr_evt),
        .clear      (clr_evt),
        .par_irq_en (q.mode[MD_PARI]),
        .eop_irq_en (q.mode[MD_EOPI]),
        .irq        (irq),
        .eop_flag   (eop_flag)
    );
endmodule

// File: rtl/scsi_bus_ctrl_chk.sv
module scsi_bus_ctrl_chk
    import scsi_ctrl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             clr_evt,
    input logic             mode_wr,
    input logic             data_en,
    input logic             arb_drive,
    input logic             arb_busy,
    input logic             arb_lost,
    input logic             arb_start,
    input logic             tgt_mode,
    input logic [CTL_W-1:0] ctl_drive,
    input logic [DW-1:0]    db_drive,
    input logic             dbp_drive
);
    // R4: outgoing byte and parity are odd together
    a_r4_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (data_en && !arb_drive) |-> (($countones({db_drive, dbp_drive}) % 2) == 1));

    // R5: target-owned lines stay released outside target mode
    a_r5_target_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_mode |-> (ctl_drive[CTL_REQ:CTL_IO] == '0));

    // R10: interrupt holds until a status read or a mask change
    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_evt && !mode_wr) |=> irq);

    // R12: in-progress and lost never show together
    a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arb_busy, arb_lost}));

    // R11: arbitration drive only follows a requested start
    a_r11_drive_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        arb_drive |-> $past(arb_start));
endmodule

bind scsi_bus_ctrl scsi_bus_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .clr_evt   (clr_evt),
    .mode_wr   (mode_wr),
    .data_en   (data_en),
    .arb_drive (arb_drive),
    .arb_busy  (arb_busy),
    .arb_lost  (arb_lost),
    .arb_start (arb_start),
    .tgt_mode  (tgt_mode),
    .ctl_drive (bus_ctl_drive),
    .db_drive  (bus_db_drive),
    .dbp_drive (bus_dbp_drive)
);

// File: tb/tb_scsi_bus_ctrl.sv
module tb_scsi_bus_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 16;
    localparam int NVEC       = 13;

    // {addr[3], wdata[8], ctl_drive[9], db_drive[8], dbp_drive[1]}
    localparam logic [28:0] VECS [NVEC] = '{
        {3'd1, 8'h80, 9'h100, 8'h00, 1'b0},   // R3 RST
        {3'd1, 8'h10, 9'h002, 8'h00, 1'b0},   // R3 ACK
        {3'd1, 8'h08, 9'h080, 8'h00, 1'b0},   // R3 BSY
        {3'd1, 8'h04, 9'h004, 8'h00, 1'b0},   // R3 SEL
        {3'd1, 8'h02, 9'h001, 8'h00, 1'b0},   // R3 ATN
        {3'd0, 8'hA5, 9'h001, 8'h00, 1'b0},   // R4 data held back
        {3'd1, 8'h01, 9'h000, 8'hA5, 1'b1},   // R4 even byte, parity set
        {3'd0, 8'h07, 9'h000, 8'h07, 1'b0},   // R4 odd byte, parity clear
        {3'd3, 8'h0F, 9'h000, 8'h07, 1'b0},   // R5 not target
        {3'd2, 8'h40, 9'h078, 8'h07, 1'b0},   // R5 target mode
        {3'd3, 8'h08, 9'h040, 8'h07, 1'b0},   // R5 REQ only
        {3'd2, 8'h00, 9'h000, 8'h07, 1'b0},   // R5 leave target
        {3'd1, 8'h00, 9'h000, 8'h00, 1'b0}    // R4 data released
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hst_addr = '0;
    logic [7:0] hst_wdata = '0;
    logic [7:0] hst_rdata;
    logic       hst_cs_n = 1'b1, hst_rd_n = 1'b1, hst_wr_n = 1'b1;
    logic       irq, dma_req;
    logic       dma_ack_n = 1'b1, eop_n = 1'b1;
    logic [8:0] bus_ctl_in_n = '1;
    logic [8:0] bus_ctl_drive;
    logic [7:0] bus_db_in_n = '1;
    logic [7:0] bus_db_drive;
    logic       bus_dbp_in_n = 1'b1;
    logic       bus_dbp_drive;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    scsi_bus_ctrl #(.SETTLE(SETTLE)) dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        hst_addr = a; hst_wdata = v; hst_cs_n = 1'b0; hst_wr_n = 1'b0;
        @(negedge clk);
        hst_cs_n = 1'b1; hst_wr_n = 1'b1;
    endtask

    task automatic hread(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        hst_addr = a; hst_cs_n = 1'b0; hst_rd_n = 1'b0;
        #1 v = hst_rdata;
        @(negedge clk);
        hst_cs_n = 1'b1; hst_rd_n = 1'b1;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ctl drive", 32'(bus_ctl_drive), 0);
        check("R1 db drive", 32'({bus_db_drive, bus_dbp_drive}), 0);
        check("R1 irq/dma", 32'({irq, dma_req}), 0);
        hread(3'd1, rv); check("R1 icmd", 32'(rv), 0);
        hread(3'd2, rv); check("R1 mode", 32'(rv), 0);
        hread(3'd3, rv); check("R1 tcmd", 32'(rv), 0);

        // R3 R4 R5 vector table
        for (int i = 0; i < NVEC; i++) begin
            hwrite(VECS[i][28:26], VECS[i][25:18]);
            check($sformatf("R3/R4/R5 vec%0d ctl", i), 32'(bus_ctl_drive), 32'(VECS[i][17:9]));
            check($sformatf("R4 vec%0d db", i), 32'(bus_db_drive), 32'(VECS[i][8:1]));
            check($sformatf("R4 vec%0d dbp", i), 32'(bus_dbp_drive), 32'(VECS[i][0]));
        end

        // R2 readback
        hwrite(3'd2, 8'hA2); hread(3'd2, rv); check("R2 mode", 32'(rv), 32'hA2);
        hwrite(3'd2, 8'h00);
        hwrite(3'd1, 8'hFE); hread(3'd1, rv); check("R2 icmd", 32'(rv), 32'h9E);
        hwrite(3'd1, 8'h00);
        hwrite(3'd3, 8'hFF); hread(3'd3, rv); check("R2 tcmd", 32'(rv), 32'h0F);
        hwrite(3'd3, 8'h00);

        // R6 sensed data and status
        hwrite(3'd0, 8'h01); hwrite(3'd1, 8'h01);
        bus_db_in_n = ~8'h30;
        hread(3'd0, rv); check("R6 data byte", 32'(rv), 32'h31);
        bus_db_in_n = '1; hwrite(3'd1, 8'h00);
        bus_ctl_in_n = ~9'h084; bus_dbp_in_n = 1'b0;
        hread(3'd4, rv); check("R6 status", 32'(rv), 32'h43);
        bus_ctl_in_n = '1; bus_dbp_in_n = 1'b1;

        // R7 parity check, R10 sticky and clear
        hwrite(3'd2, 8'h30);
        bus_db_in_n = ~8'h01;
        hread(3'd0, rv); check("R7 good parity irq", 32'(irq), 0);
        bus_dbp_in_n = 1'b0;
        hread(3'd0, rv); check("R7 bad parity irq", 32'(irq), 1);
        bus_dbp_in_n = 1'b1;
        cycles(5); check("R10 irq held", 32'(irq), 1);
        hread(3'd4, rv); check("R10 irq cleared", 32'(irq), 0);
        hwrite(3'd2, 8'h10);
        bus_dbp_in_n = 1'b0;
        hread(3'd0, rv); check("R7 check disabled", 32'(irq), 0);
        bus_dbp_in_n = 1'b1; bus_db_in_n = '1;
        hwrite(3'd2, 8'h30); check("R7 no flag stored", 32'(irq), 0);
        hwrite(3'd2, 8'h00);

        // R8 end of process
        hwrite(3'd2, 8'h08);
        @(negedge clk); eop_n = 1'b0; @(negedge clk); eop_n = 1'b1;
        check("R8 eop irq", 32'(irq), 1);
        hread(3'd3, rv); check("R8 last byte flag", 32'(rv), 32'h80);
        hread(3'd4, rv); check("R8 irq cleared", 32'(irq), 0);
        hread(3'd3, rv); check("R10 flag cleared", 32'(rv), 0);
        hwrite(3'd2, 8'h00);
        @(negedge clk); eop_n = 1'b0; @(negedge clk); eop_n = 1'b1;
        check("R8 masked eop", 32'(irq), 0);
        hread(3'd3, rv); check("R8 masked flag", 32'(rv), 32'h80);
        hread(3'd4, rv);

        // R9 busy monitor exact timing
        hwrite(3'd2, 8'h04);
        repeat (SETTLE - 1) @(posedge clk);
        #1 check("R9 before settle", 32'(irq), 0);
        @(posedge clk);
        #1 check("R9 at settle", 32'(irq), 1);
        hread(3'd4, rv); cycles(SETTLE + 2);
        check("R9 no refire", 32'(irq), 0);
        hwrite(3'd2, 8'h00);
        bus_ctl_in_n[7] = 1'b0;
        hwrite(3'd2, 8'h04); cycles(2 * SETTLE);
        check("R9 busy held", 32'(irq), 0);
        hwrite(3'd2, 8'h00); bus_ctl_in_n = '1;

        // R11 arbitration win
        hwrite(3'd4, 8'h08);
        hwrite(3'd2, 8'h01); cycles(3);
        hread(3'd1, rv); check("R11 in progress", 32'(rv), 32'h40);
        check("R11 no early drive", 32'(bus_db_drive), 0);
        cycles(2 * SETTLE + 5);
        check("R11 bsy driven", 32'(bus_ctl_drive), 32'h080);
        check("R11 id driven", 32'(bus_db_drive), 32'h08);
        hread(3'd1, rv); check("R11 won flags", 32'(rv), 32'h40);
        hwrite(3'd2, 8'h00); cycles(2);
        check("R11 released", 32'({bus_ctl_drive, bus_db_drive}), 0);

        // R12 higher id present
        bus_db_in_n = ~8'h20;
        hwrite(3'd2, 8'h01); cycles(2 * SETTLE + 10);
        check("R12 no drive", 32'({bus_ctl_drive, bus_db_drive}), 0);
        hread(3'd1, rv); check("R12 lost flag", 32'(rv), 32'h20);
        hwrite(3'd2, 8'h00);
        // R11 lower id does not beat own id
        bus_db_in_n = ~8'h02;
        hwrite(3'd2, 8'h01); cycles(2 * SETTLE + 10);
        check("R11 lower id win", 32'(bus_db_drive), 32'h08);
        hwrite(3'd2, 8'h00); bus_db_in_n = '1;
        // R12 SEL seen
        bus_ctl_in_n[2] = 1'b0;
        hwrite(3'd2, 8'h01); cycles(2 * SETTLE + 10);
        hread(3'd1, rv); check("R12 sel lost", 32'(rv), 32'h20);
        hwrite(3'd2, 8'h00); bus_ctl_in_n = '1;

        // R13 DMA request
        hwrite(3'd2, 8'h02);
        check("R13 no req", 32'(dma_req), 0);
        @(negedge clk); bus_ctl_in_n[6] = 1'b0; #1;
        check("R13 req", 32'(dma_req), 1);
        dma_ack_n = 1'b0; #1;
        check("R13 acked", 32'(dma_req), 0);
        dma_ack_n = 1'b1;
        hwrite(3'd2, 8'h00);
        check("R13 mode off", 32'(dma_req), 0);
        bus_ctl_in_n = '1;

        finish_run();
    end
endmodule